// File: doc/BRIEF.md
# Shadow Region Attribute Decoder

This block decides, for the legacy upper memory area between 0xC0000 and 0xFFFFF, whether an access is served by internal DRAM or forwarded to the external bus. Seven control bytes, loaded through a simple byte write port, set read and write routing for thirteen regions. Six bytes each cover a 32 KB window split into two 16 KB halves. The seventh covers the 64 KB region at the top of the area and also holds a global switch for bus-master shadowing. A combinational lookup port takes an address, an access direction and an initiator type (processor or bus master) and returns two flags: whether the address lies in the shadowed area, and whether the access is routed internally.

Two routing views are kept. The processor view follows the control bytes directly. The bus-master view matches the processor view only while the global switch is set. While it is clear, every bus-master access is forced to the external bus.

A small two-state machine watches for changes in the routing that is in effect. It stays in ST_IDLE until a control write arrives (transition IDLE->EVAL). ST_EVAL compares the new per-region routing of both views against a stored snapshot, reports the differences, and refreshes the snapshot. It then either returns to ST_IDLE (EVAL->IDLE, no write pending) or stays in ST_EVAL for a write that follows directly (EVAL->EVAL). The change report is a one-cycle pulse with one mask bit per region for each view. Other logic can use it to invalidate cached translations.

Top module: `shadow_attr_decoder`

## Requirements
- R1: After reset all seven control bytes read 0x00, every region routes reads and writes externally in both views, and no change pulse is raised.
- R2: For control byte k (k = 0..5), governing 0xC0000 + k*0x8000 through +0x3FFF (region 2k), bit 7 set routes reads internally and bit 5 set routes writes internally; a clear bit routes that access type externally.
- R3: For control byte k (k = 0..5), the upper half 0xC4000 + k*0x8000 through +0x3FFF (region 2k+1) uses bit 3 for reads and bit 1 for writes in the same way.
- R4: Control byte 6 governs the whole region 0xF0000 to 0xFFFFF (region 12), with bit 7 for reads and bit 5 for writes.
- R5: A write to index 0..5 stores the data ANDed with 0xEE, a write to index 6 stores the data ANDed with 0xE8, and a write to index 7 changes nothing; reading index 7 returns 0x00.
- R6: While bit 3 of control byte 6 is clear, every bus-master access is routed externally whatever the other bits hold, and the processor view does not change.
- R7: While bit 3 of control byte 6 is set, the bus-master view routes each region exactly as the processor view does.
- R8: An address below 0xC0000 reports in-window = 0 and internal = 0.
- R9: A control write raises chg_valid for exactly one cycle, in the second cycle after the clock edge that takes the write. The cpu and bus-master masks mark each region whose effective read or write routing changed in that view. A write that changes no effective routing raises no pulse, and the masks are zero whenever chg_valid is low.
- R10: Writes on consecutive clock edges are each reported separately and in order, one pulse per write on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Control byte write strobe |
| cfg_wr_idx | input | 3 | Control byte index for the write |
| cfg_wr_data | input | 8 | Write data before masking |
| cfg_rd_idx | input | 3 | Control byte index for readback |
| cfg_rd_data | output | 8 | Stored control byte (0 for an unused index) |
| acc_addr | input | 20 | Access address |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_busmaster | input | 1 | 1 = bus-master initiator, 0 = processor |
| acc_in_window | output | 1 | Address lies in the shadowed area |
| acc_internal | output | 1 | Access is routed to internal DRAM |
| chg_valid | output | 1 | One-cycle routing change pulse |
| chg_cpu_mask | output | 13 | Regions whose processor routing changed |
| chg_bm_mask | output | 13 | Regions whose bus-master routing changed |

## Verification
The bench builds the block with its default parameters: six 32 KB windows, a 20-bit address and a base of 0xC0000. This gives thirteen regions whose edges fall on exact 16 KB and 64 KB boundaries. With seven bytes on a 3-bit index, the unused index 7 can be reached, so ignored writes can be tested. The top region ends at the last address the port can express, so boundary probes at 0xBFFFF, 0xEFFFF, 0xF0000 and 0xFFFFF all test real decode edges. The defaults also allow a final sweep of every region in both views and both directions against a model of the control bytes.

// File: rtl/shadow_pkg.sv
`timescale 1ns/1ps
package shadow_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } chg_state_e;

    // Routing of one region: rd/wr = 1 means internal DRAM.
    typedef struct packed {
        logic rd;
        logic wr;
    } route_t;

    localparam logic [7:0] WIN_WMASK = 8'hEE;
    localparam logic [7:0] TOP_WMASK = 8'hE8;

    localparam int LO_RD_BIT = 7;
    localparam int LO_WR_BIT = 5;
    localparam int HI_RD_BIT = 3;
    localparam int HI_WR_BIT = 1;
    localparam int BM_EN_BIT = 3;

endpackage

// File: rtl/shadow_regfile.sv
`timescale 1ns/1ps
module shadow_regfile
    import shadow_pkg::*;
#(
    parameter int N_WIN = 6,
    parameter int IDX_W = 3,
    localparam int N_REG = N_WIN + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [N_REG-1:0][7:0] regs_o
);

    logic [N_REG-1:0][7:0] regs_q;

    for (genvar gi = 0; gi < N_REG; gi++) begin : g_reg
        localparam logic [7:0] WMASK = (gi == N_WIN) ? TOP_WMASK : WIN_WMASK;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[gi] <= 8'h00;
            end else if (wr_en && (wr_idx == IDX_W'(gi))) begin
                regs_q[gi] <= wr_data & WMASK;
            end
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < N_REG; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = regs_q[i];
            end
        end
    end

    assign regs_o = regs_q;

    if (N_REG < (1 << IDX_W)) begin : g_oor_chk
        AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_idx >= IDX_W'(N_REG))) |=> $stable(regs_q)); // R5
    end

endmodule

// File: rtl/shadow_route.sv
`timescale 1ns/1ps
module shadow_route
    import shadow_pkg::*;
#(
    parameter int N_WIN = 6,
    localparam int N_REG = N_WIN + 1,
    localparam int N_REGION = 2 * N_WIN + 1
) (
    input  logic [N_REG-1:0][7:0]    regs_i,
    output route_t [N_REGION-1:0]    cpu_eff,
    output route_t [N_REGION-1:0]    bm_eff
);

    logic bm_on;
    logic unused_rsvd;

    assign bm_on = regs_i[N_WIN][BM_EN_BIT];

    for (genvar gw = 0; gw < N_WIN; gw++) begin : g_win
        assign cpu_eff[2*gw]   = {regs_i[gw][LO_RD_BIT], regs_i[gw][LO_WR_BIT]};
        assign cpu_eff[2*gw+1] = {regs_i[gw][HI_RD_BIT], regs_i[gw][HI_WR_BIT]};
    end

    assign cpu_eff[N_REGION-1] = {regs_i[N_WIN][LO_RD_BIT], regs_i[N_WIN][LO_WR_BIT]};

    for (genvar gr = 0; gr < N_REGION; gr++) begin : g_bm
        assign bm_eff[gr] = bm_on ? cpu_eff[gr] : route_t'(2'b00);
    end

    assign unused_rsvd = ^regs_i;

endmodule

// File: rtl/shadow_lookup.sv
`timescale 1ns/1ps
module shadow_lookup
    import shadow_pkg::*;
#(
    parameter int              N_WIN     = 6,
    parameter int              ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 20'hC0000,
    localparam int N_REGION  = 2 * N_WIN + 1,
    localparam int HALF_LOG2 = 14,
    localparam int TOP_LOG2  = 16,
    localparam int WIN_SPAN  = N_WIN << (HALF_LOG2 + 1),
    localparam int TOP_END   = WIN_SPAN + (1 << TOP_LOG2),
    localparam int SEL_W     = $clog2(N_REGION)
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   is_write,
    input  logic                   is_bm,
    input  route_t [N_REGION-1:0]  cpu_eff,
    input  route_t [N_REGION-1:0]  bm_eff,
    output logic                   in_window,
    output logic                   internal
);

    logic [ADDR_W-1:0] off;
    logic [SEL_W-1:0]  sel;
    route_t            pick;

    assign off = addr - BASE_ADDR;

    always_comb begin
        in_window = 1'b0;
        sel       = '0;
        if (addr >= BASE_ADDR) begin
            if (off < ADDR_W'(WIN_SPAN)) begin
                in_window = 1'b1;
                sel       = SEL_W'(off >> HALF_LOG2);
            end else if (off < ADDR_W'(TOP_END)) begin
                in_window = 1'b1;
                sel       = SEL_W'(N_REGION - 1);
            end
        end
    end

    always_comb begin
        pick = route_t'(2'b00);
        for (int r = 0; r < N_REGION; r++) begin
            if (sel == SEL_W'(r)) begin
                pick = is_bm ? bm_eff[r] : cpu_eff[r];
            end
        end
        internal = in_window & (is_write ? pick.wr : pick.rd);
    end

endmodule

// File: rtl/shadow_change_fsm.sv
`timescale 1ns/1ps
module shadow_change_fsm
    import shadow_pkg::*;
#(
    parameter int N_REGION = 13
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  route_t [N_REGION-1:0]  cpu_eff,
    input  route_t [N_REGION-1:0]  bm_eff,
    output logic                   chg_valid,
    output logic [N_REGION-1:0]    chg_cpu_mask,
    output logic [N_REGION-1:0]    chg_bm_mask
);

    chg_state_e st_q, st_d;
    route_t [N_REGION-1:0] cpu_prev_q, bm_prev_q;
    logic   [N_REGION-1:0] cpu_diff, bm_diff;

    for (genvar g = 0; g < N_REGION; g++) begin : g_diff
        assign cpu_diff[g] = |(cpu_eff[g] ^ cpu_prev_q[g]);
        assign bm_diff[g]  = |(bm_eff[g] ^ bm_prev_q[g]);
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (wr_en) st_d = ST_EVAL;
            ST_EVAL: st_d = wr_en ? ST_EVAL : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_prev_q   <= '0;
            bm_prev_q    <= '0;
            chg_valid    <= 1'b0;
            chg_cpu_mask <= '0;
            chg_bm_mask  <= '0;
        end else if (st_q == ST_EVAL) begin
            cpu_prev_q   <= cpu_eff;
            bm_prev_q    <= bm_eff;
            chg_valid    <= |{cpu_diff, bm_diff};
            chg_cpu_mask <= cpu_diff;
            chg_bm_mask  <= bm_diff;
        end else begin
            chg_valid    <= 1'b0;
            chg_cpu_mask <= '0;
            chg_bm_mask  <= '0;
        end
    end

    AST_PULSE_FROM_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        chg_valid |-> $past(st_q == ST_EVAL)); // R9
    AST_WRITE_ENTERS_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && $past(rst_n)) |-> (st_q == ST_EVAL)); // R10
    AST_QUIET_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_valid |-> ((chg_cpu_mask == '0) && (chg_bm_mask == '0))); // R9

endmodule

// File: rtl/shadow_attr_decoder.sv
`timescale 1ns/1ps
module shadow_attr_decoder
    import shadow_pkg::*;
#(
    parameter int                N_WIN     = 6,
    parameter int                ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 20'hC0000,
    localparam int N_REG    = N_WIN + 1,
    localparam int N_REGION = 2 * N_WIN + 1,
    localparam int IDX_W    = $clog2(N_REG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [IDX_W-1:0]    cfg_wr_idx,
    input  logic [7:0]          cfg_wr_data,
    input  logic [IDX_W-1:0]    cfg_rd_idx,
    output logic [7:0]          cfg_rd_data,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic                acc_write,
    input  logic                acc_busmaster,
    output logic                acc_in_window,
    output logic                acc_internal,
    output logic                chg_valid,
    output logic [N_REGION-1:0] chg_cpu_mask,
    output logic [N_REGION-1:0] chg_bm_mask
);

    logic [N_REG-1:0][7:0] regs;
    route_t [N_REGION-1:0] cpu_eff, bm_eff;

    shadow_regfile #(.N_WIN(N_WIN), .IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_idx  (cfg_wr_idx),
        .wr_data (cfg_wr_data),
        .rd_idx  (cfg_rd_idx),
        .rd_data (cfg_rd_data),
        .regs_o  (regs)
    );

    shadow_route #(.N_WIN(N_WIN)) u_route (
        .regs_i  (regs),
        .cpu_eff (cpu_eff),
        .bm_eff  (bm_eff)
    );

    shadow_lookup #(.N_WIN(N_WIN), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_lookup (
        .addr      (acc_addr),
        .is_write  (acc_write),
        .is_bm     (acc_busmaster),
        .cpu_eff   (cpu_eff),
        .bm_eff    (bm_eff),
        .in_window (acc_in_window),
        .internal  (acc_internal)
    );

    shadow_change_fsm #(.N_REGION(N_REGION)) u_chg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (cfg_wr_en),
        .cpu_eff      (cpu_eff),
        .bm_eff       (bm_eff),
        .chg_valid    (chg_valid),
        .chg_cpu_mask (chg_cpu_mask),
        .chg_bm_mask  (chg_bm_mask)
    );

    AST_OUTSIDE_EXTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_in_window |-> !acc_internal); // R8
    AST_BM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !regs[N_WIN][BM_EN_BIT] |-> (bm_eff == '0)); // R6
    AST_BM_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        regs[N_WIN][BM_EN_BIT] |-> (bm_eff == cpu_eff)); // R7

endmodule

// File: tb/shadow_attr_decoder_tb_top.sv
`timescale 1ns/1ps
module shadow_attr_decoder_tb_top;

    typedef struct {
        int          kind;   // 0 route, 1 readback, 2 change
        string       req;
        logic [31:0] exp_a;
        logic [31:0] exp_b;
        logic [31:0] exp_c;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_idx = '0;
    logic [7:0]  cfg_wr_data = '0;
    logic [2:0]  cfg_rd_idx = '0;
    logic [7:0]  cfg_rd_data;
    logic [19:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        acc_busmaster = 1'b0;
    logic        acc_in_window, acc_internal, chg_valid;
    logic [12:0] chg_cpu_mask, chg_bm_mask;

    item_t sb_q[$];
    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] mdl [0:6];
    bit done = 0;

    always #2.5 clk = ~clk;

    shadow_attr_decoder dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data),
        .acc_addr(acc_addr), .acc_write(acc_write), .acc_busmaster(acc_busmaster),
        .acc_in_window(acc_in_window), .acc_internal(acc_internal),
        .chg_valid(chg_valid), .chg_cpu_mask(chg_cpu_mask), .chg_bm_mask(chg_bm_mask)
    );

    // ---------------- model from the requirements ----------------
    function automatic logic [1:0] m_route(int region, bit bm); // {rd, wr}
        logic [7:0] b;
        logic [1:0] r;
        if (region == 12) begin
            b = mdl[6]; r = {b[7], b[5]};
        end else begin
            b = mdl[region / 2];
            r = (region % 2) ? {b[3], b[1]} : {b[7], b[5]};
        end
        if (bm && !mdl[6][3]) r = 2'b00;
        return r;
    endfunction

    function automatic logic [1:0] m_lookup(logic [19:0] a, bit wr, bit bm); // {in, int}
        int rg;
        logic [1:0] r;
        if (a < 20'hC0000) return 2'b00;
        if (a < 20'hF0000) rg = int'((a - 20'hC0000) >> 14);
        else rg = 12;
        r = m_route(rg, bm);
        return {1'b1, wr ? r[0] : r[1]};
    endfunction

    function automatic logic [25:0] m_snap(bit bm);
        logic [25:0] s;
        for (int r = 0; r < 13; r++) s[2*r +: 2] = m_route(r, bm);
        return s;
    endfunction

    function automatic logic [12:0] m_diff(logic [25:0] a, logic [25:0] b);
        logic [12:0] d;
        for (int r = 0; r < 13; r++) d[r] = |(a[2*r +: 2] ^ b[2*r +: 2]);
        return d;
    endfunction

    function automatic void m_apply(logic [2:0] idx, logic [7:0] data);
        if (idx < 3'd6) mdl[idx] = data & 8'hEE;
        else if (idx == 3'd6) mdl[idx] = data & 8'hE8;
    endfunction

    function automatic void push_chg(logic [25:0] c0, logic [25:0] c1,
                                     logic [25:0] b0, logic [25:0] b1, string req);
        item_t it;
        it.kind  = 2;
        it.req   = req;
        it.exp_b = {19'd0, m_diff(c0, c1)};
        it.exp_c = {19'd0, m_diff(b0, b1)};
        it.exp_a = {31'd0, |{it.exp_b, it.exp_c}};
        sb_q.push_back(it);
    endfunction

    // ---------------- driver tasks ----------------
    task automatic do_write(input logic [2:0] idx, input logic [7:0] data, input string req);
        logic [25:0] c0, b0;
        c0 = m_snap(0); b0 = m_snap(1);
        m_apply(idx, data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_idx = idx; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        push_chg(c0, m_snap(0), b0, m_snap(1), req);
    endtask

    task automatic do_write_pair(input logic [2:0] i1, input logic [7:0] d1,
                                 input logic [2:0] i2, input logic [7:0] d2, input string req);
        logic [25:0] c0, b0, c1, b1;
        c0 = m_snap(0); b0 = m_snap(1);
        m_apply(i1, d1);
        c1 = m_snap(0); b1 = m_snap(1);
        m_apply(i2, d2);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_idx = i1; cfg_wr_data = d1;
        @(negedge clk);
        cfg_wr_idx = i2; cfg_wr_data = d2;
        push_chg(c0, c1, b0, b1, req);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        push_chg(c1, m_snap(0), b1, m_snap(1), req);
    endtask

    task automatic probe(input logic [19:0] a, input bit wr, input bit bm, input string req);
        item_t it;
        @(negedge clk);
        acc_addr = a; acc_write = wr; acc_busmaster = bm;
        it.kind = 0; it.req = req;
        it.exp_a = {30'd0, m_lookup(a, wr, bm)};
        it.exp_b = {12'd0, a}; it.exp_c = 0;
        sb_q.push_back(it);
    endtask

    task automatic read_chk(input logic [2:0] idx, input string req);
        item_t it;
        @(negedge clk);
        cfg_rd_idx = idx;
        it.kind = 1; it.req = req;
        it.exp_a = (idx < 3'd7) ? {24'd0, mdl[idx]} : 32'd0;
        it.exp_b = {29'd0, idx}; it.exp_c = 0;
        sb_q.push_back(it);
    endtask

    task automatic quiet_chk(input string req);
        @(negedge clk);
        push_chg(m_snap(0), m_snap(0), m_snap(1), m_snap(1), req);
    endtask

    // ---------------- monitor / scoreboard ----------------
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (it.kind == 0) begin
                    if ({acc_in_window, acc_internal} !== it.exp_a[1:0]) begin
                        n_errors++;
                        $display("FAIL %s: addr %h route actual=%b expected=%b",
                                 it.req, it.exp_b[19:0], {acc_in_window, acc_internal}, it.exp_a[1:0]);
                    end
                end else if (it.kind == 1) begin
                    if (cfg_rd_data !== it.exp_a[7:0]) begin
                        n_errors++;
                        $display("FAIL %s: idx %0d read actual=%h expected=%h",
                                 it.req, it.exp_b, cfg_rd_data, it.exp_a[7:0]);
                    end
                end else begin
                    if ({chg_valid, chg_cpu_mask, chg_bm_mask} !==
                        {it.exp_a[0], it.exp_b[12:0], it.exp_c[12:0]}) begin
                        n_errors++;
                        $display("FAIL %s: change actual=%b/%h/%h expected=%b/%h/%h", it.req,
                                 chg_valid, chg_cpu_mask, chg_bm_mask,
                                 it.exp_a[0], it.exp_b[12:0], it.exp_c[12:0]);
                    end
                end
            end
        end
    end

    task automatic finish_sim();
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_sim();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < 7; i++) mdl[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 7; i++) read_chk(3'(i), "R1");
        probe(20'hC0000, 0, 0, "R1");
        probe(20'hF8000, 1, 1, "R1");
        quiet_chk("R1");

        // R2/R3/R5/R9: lower and upper halves of window 0
        do_write(3'd0, 8'hFF, "R9");
        read_chk(3'd0, "R5");
        probe(20'hC0000, 0, 0, "R2");
        probe(20'hC3FFF, 1, 0, "R2");
        probe(20'hC4000, 0, 0, "R3");
        probe(20'hC7FFF, 1, 0, "R3");
        probe(20'hC0000, 0, 1, "R6");

        // R9: rewrite of the same value gives no pulse
        do_write(3'd0, 8'hEE, "R9");
        // R9/R5: only masked bits set
        do_write(3'd0, 8'h11, "R9");
        read_chk(3'd0, "R5");

        // R2/R3: read-only lower half of window 5
        do_write(3'd5, 8'h80, "R9");
        probe(20'hE8000, 0, 0, "R2");
        probe(20'hE8000, 1, 0, "R2");
        probe(20'hEC000, 0, 0, "R3");

        // R4/R7: top region and bus-master enable
        do_write(3'd6, 8'hFF, "R9");
        read_chk(3'd6, "R5");
        probe(20'hF0000, 0, 0, "R4");
        probe(20'hFFFFF, 1, 0, "R4");
        probe(20'hE8000, 0, 1, "R7");
        probe(20'hE8000, 1, 1, "R7");

        // R8: outside the window, and decode edges
        probe(20'hBFFFF, 0, 0, "R8");
        probe(20'h00000, 1, 1, "R8");
        probe(20'hEFFFF, 0, 0, "R3");

        // R5: index 7 ignored
        do_write(3'd7, 8'hFF, "R5");
        for (int i = 0; i < 8; i++) read_chk(3'(i), "R5");

        // R10: back-to-back writes, second one disables bus-master shadow
        do_write_pair(3'd1, 8'h22, 3'd6, 8'hA0, "R10");
        probe(20'hF0000, 0, 1, "R6");
        probe(20'hF0000, 0, 0, "R6");
        probe(20'hC8000, 1, 0, "R2");

        // R3/R6: upper half of window 2
        do_write(3'd2, 8'h0A, "R9");
        probe(20'hD4000, 0, 0, "R3");
        probe(20'hD4000, 0, 1, "R6");

        // R7: re-enable bus-master shadow, sweep every region
        do_write(3'd6, 8'h28, "R7");
        for (int r = 0; r < 13; r++) begin
            for (int v = 0; v < 4; v++) begin
                probe(20'hC0000 + 20'(r * 20'h4000) + 20'h0100, v[0], v[1], "R7");
            end
        end
        quiet_chk("R9");

        repeat (3) @(negedge clk);
        done = 1;
        finish_sim();
    end

endmodule